// File: doc/BRIEF.md
# Flash Bulk-Program Sequencer

This block is the device-side control for a high-throughput programming mode of a small flash array. A host drives plain bus write cycles (address and data) and polls a status byte. A two-write unlock (0x30 then 0xD0) arms the mode for the block that the first write addressed. The block then moves through four phases in a fixed order: setup, program, verify and exit.

Setup spends a fixed number of cycles on its checks, then tests the programming-voltage input and the target block's lock bit. In the program phase every write that lands inside the target block is taken as data with no command in front of it. Each such write gets one timed program pulse, modelled as a bitwise AND into the stored word. A write that lands outside the block ends streaming and starts verify. Verify walks the block and pulses again any word that still holds ones where zeros were written, up to a retry limit. Exit raises the ready bit and gives the bus back to array reads.

The array is a register model that resets to all ones. A `cell_weak` input lets a test make pulses miss, which exercises the verify path.

Top module: `fbp_ctrl`

## Requirements
- R1: After reset, `status` reads 0x80 (bit 7 ready = 1, all other bits 0) and every array word reads back all ones on `rd_data`.
- R2: The mode is entered only by a write whose data low byte is 0x30 followed by a write whose data low byte is 0xD0. Any other second byte returns to read-array with no change, and a lone 0xD0 has no effect.
- R3: On the accepted 0xD0 write, `status` becomes 0x00 (bit 7 falls and earlier error bits clear). While the mode is active, `rd_data` returns the status byte instead of array data.
- R4: When setup ends after SETUP_CYC cycles with `vpp_ok` low, status bit 3 is set, the mode exits with bit 7 = 1, and the array is unchanged.
- R5: When setup ends with the target block's bit of `lock_mask` set, status bit 1 is set and the mode exits the same way.
- R6: Each in-block data write during the program phase holds status bit 0 at 1 for exactly PULSE_CYC cycles, then returns it to 0 (ready for the next word).
- R7: A program-phase write needs no command prefix. Its address then holds the old word ANDed with the written data, so bits only go from 1 to 0.
- R8: Writes that arrive while status bit 0 is 1 are ignored.
- R9: A program-phase write outside the target block leaves that address unchanged and starts verify, which ends in exit: `status` bit 7 returns to 1 and `rd_data` returns array data.
- R10: Verify pulses again any target word that still has ones where zeros were written. A word whose pulse missed (`cell_weak` high at the pulse end) ends up correct, with status bit 4 clear.
- R11: If a word still fails after MAX_RETRY verify pulses, status bit 4 is set and the mode exits.
- R12: Error bits 4, 3 and 1 stay set in read-array mode until the next accepted 0xD0 write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; the low byte carries commands |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data: array word when idle, status byte while active |
| vpp_ok | input | 1 | Programming voltage within range |
| lock_mask | input | NBLK | One lock bit per block |
| cell_weak | input | 1 | When high at the end of a pulse, that pulse does not change the array |
| status | output | 8 | Status byte: 7 ready, 4 program fail, 3 low voltage, 1 locked, 0 pulse busy |

## Verification
The data stream is driven with several patterns. Single writes show the AND storage. A repeated write to one word separates AND from overwrite. A write issued while a pulse is still busy must be dropped. A write outside the block separates an early exit from normal streaming. The voltage and lock faults are driven one at a time, so each error bit is tied to its own cause. The error bits are also observed across an idle write and a later unlock. Holding `cell_weak` for a single pulse, and then for the whole run, separates a verify repair from a retry-limit failure.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_SETUP, ST_PROG, ST_PULSE, ST_VSCAN, ST_VPULSE, ST_EXIT
  } fbp_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'h30;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam int SB_READY = 7;
  localparam int SB_PFAIL = 4;
  localparam int SB_VLOW  = 3;
  localparam int SB_LOCK  = 1;
  localparam int SB_BUSY  = 0;
endpackage

// File: rtl/fbp_array.sv
`timescale 1ns/1ps
module fbp_array #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == '0));
endmodule

// File: rtl/fbp_timer.sv
`timescale 1ns/1ps
module fbp_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fbp_mark.sv
`timescale 1ns/1ps
module fbp_mark #(
  parameter int DW  = 8,
  parameter int WPB = 8,
  localparam int OW = $clog2(WPB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [OW-1:0] idx,
  input  logic [DW-1:0] data,
  input  logic [OW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] want [WPB];

  for (genvar g = 0; g < WPB; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clr)                     want[g] <= '1;
      else if (we && idx == OW'(g))       want[g] <= want[g] & data;
    end
  end

  assign rd_data = want[rd_idx];
endmodule

// File: rtl/fbp_ctrl.sv
`timescale 1ns/1ps
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int WPB       = 8,
  parameter int NBLK      = 4,
  parameter int SETUP_CYC = 6,
  parameter int PULSE_CYC = 4,
  parameter int MAX_RETRY = 3,
  localparam int OW       = $clog2(WPB),
  localparam int BW       = $clog2(NBLK),
  localparam int AW       = OW + BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            vpp_ok,
  input  logic [NBLK-1:0] lock_mask,
  input  logic            cell_weak,
  output logic [7:0]      status
);
  localparam int TMAX = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);

  fbp_state_e    state_q;
  logic [7:0]    status_q;
  logic [BW-1:0] tgt_q;
  logic [OW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic [RW-1:0] retry_q;
  logic [DW-1:0] rd_data_q;

  logic          go_arm, go_setup, in_blk, prog_wr, leave_blk;
  logic          fault_v, fault_l, scan_bad, give_up, re_pulse, pulse_end;
  logic          tmr_load, tmr_done, arr_we, active;
  logic [TW-1:0] tmr_len;
  logic [DW-1:0] cur_word, want_word, need, arr_wdata, arr_rd_b;

  // strobes
  always_comb begin
    go_arm    = (state_q == ST_IDLE) && wr_en && (wr_data[7:0] == CMD_SETUP);
    go_setup  = (state_q == ST_ARM) && wr_en && (wr_data[7:0] == CMD_CONFIRM);
    in_blk    = (wr_addr[AW-1:OW] == tgt_q);
    prog_wr   = (state_q == ST_PROG) && wr_en && in_blk;
    leave_blk = (state_q == ST_PROG) && wr_en && !in_blk;
    fault_v   = !vpp_ok;
    fault_l   = lock_mask[tgt_q];
    need      = cur_word & ~want_word;
    scan_bad  = (state_q == ST_VSCAN) && (need != '0);
    give_up   = scan_bad && (retry_q == RW'(MAX_RETRY));
    re_pulse  = scan_bad && !give_up;
    pulse_end = ((state_q == ST_PULSE) || (state_q == ST_VPULSE)) && tmr_done;
    tmr_load  = go_setup || prog_wr || re_pulse;
    tmr_len   = go_setup ? TW'(SETUP_CYC - 1) : TW'(PULSE_CYC - 1);
    arr_we    = pulse_end && !cell_weak;
    arr_wdata = (state_q == ST_PULSE) ? (cur_word & data_q) : (cur_word & want_word);
    active    = !(state_q inside {ST_IDLE, ST_ARM});
  end

  fbp_array #(.DW(DW), .DEPTH(NBLK * WPB)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .waddr ({tgt_q, idx_q}),
    .wdata (arr_wdata),
    .ra_a  ({tgt_q, idx_q}),
    .rd_a  (cur_word),
    .ra_b  (rd_addr),
    .rd_b  (arr_rd_b)
  );

  fbp_timer #(.TW(TW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .done (tmr_done)
  );

  fbp_mark #(.DW(DW), .WPB(WPB)) u_mark (
    .clk     (clk),
    .rst     (rst),
    .clr     (go_setup),
    .we      (prog_wr),
    .idx     (wr_addr[OW-1:0]),
    .data    (wr_data),
    .rd_idx  (idx_q),
    .rd_data (want_word)
  );

  // phase sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      status_q <= 8'h80;
      tgt_q    <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      retry_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_arm) begin
          tgt_q   <= wr_addr[AW-1:OW];
          state_q <= ST_ARM;
        end
        ST_ARM: if (wr_en) begin
          if (go_setup) begin
            status_q <= 8'h00;
            state_q  <= ST_SETUP;
          end else begin
            state_q  <= ST_IDLE;
          end
        end
        ST_SETUP: if (tmr_done) begin
          if (fault_v || fault_l) begin
            status_q[SB_VLOW] <= fault_v;
            status_q[SB_LOCK] <= fault_l;
            state_q           <= ST_EXIT;
          end else begin
            state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (prog_wr) begin
            idx_q             <= wr_addr[OW-1:0];
            data_q            <= wr_data;
            status_q[SB_BUSY] <= 1'b1;
            state_q           <= ST_PULSE;
          end else if (leave_blk) begin
            idx_q   <= '0;
            retry_q <= '0;
            state_q <= ST_VSCAN;
          end
        end
        ST_PULSE: if (tmr_done) begin
          status_q[SB_BUSY] <= 1'b0;
          state_q           <= ST_PROG;
        end
        ST_VSCAN: begin
          if (give_up) begin
            status_q[SB_PFAIL] <= 1'b1;
            state_q            <= ST_EXIT;
          end else if (re_pulse) begin
            retry_q <= retry_q + 1'b1;
            state_q <= ST_VPULSE;
          end else if (idx_q == OW'(WPB - 1)) begin
            state_q <= ST_EXIT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            retry_q <= '0;
          end
        end
        ST_VPULSE: if (tmr_done) state_q <= ST_VSCAN;
        ST_EXIT: begin
          status_q[SB_READY] <= 1'b1;
          state_q            <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_q <= '0;
    else     rd_data_q <= active ? DW'(status_q) : arr_rd_b;
  end

  assign rd_data = rd_data_q;
  assign status  = status_q;

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[SB_READY]) |-> $past(wr_en && wr_data[7:0] == CMD_CONFIRM));
  // R6
  pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[SB_BUSY] |-> !status_q[SB_READY]);
  // R4
  vlow_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[SB_VLOW]) |=> status_q[SB_READY]);
  // R11
  pfail_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[SB_PFAIL]) |=> status_q[SB_READY]);
endmodule

// File: tb/fbp_ctrl_bench.sv
`timescale 1ns/1ps
module fbp_ctrl_bench;
  localparam int DW = 8, WPB = 8, NBLK = 4, SETUP_CYC = 6, PULSE_CYC = 4, MAX_RETRY = 3;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [DW-1:0]   rd_data;
  logic            vpp_ok = 1'b1;
  logic [NBLK-1:0] lock_mask = '0;
  logic            cell_weak = 1'b0;
  logic [7:0]      status;

  fbp_ctrl #(.DW(DW), .WPB(WPB), .NBLK(NBLK), .SETUP_CYC(SETUP_CYC),
             .PULSE_CYC(PULSE_CYC), .MAX_RETRY(MAX_RETRY)) u_fbp_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vpp_ok(vpp_ok), .lock_mask(lock_mask),
    .cell_weak(cell_weak), .status(status));

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic rd_req = 1'b0, req_d = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) req_d <= rd_req;
  always @(negedge clk) begin
    if (req_d && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rd_data, e);
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk); rd_addr = a; exp_q.push_back(e); tag_q.push_back(tag); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic wait_bit(input int b, input logic v);
    for (int i = 0; i < 500; i++) begin
      if (status[b] == v) break;
      @(negedge clk);
    end
  endtask

  task automatic start_mode(input logic [AW-1:0] a);
    bus_wr(a, 8'h30);
    bus_wr(a, 8'hD0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", status, 8'h80);
    rd_expect(0, 8'hFF, "R1 word 0");
    rd_expect(31, 8'hFF, "R1 word 31");

    // R2: bad second byte, lone confirm
    bus_wr(8, 8'h30); bus_wr(8, 8'h55);
    chk("R2 wrong confirm", status, 8'h80);
    bus_wr(8, 8'hD0);
    chk("R2 lone confirm", status, 8'h80);
    rd_expect(8, 8'hFF, "R2 array untouched");

    // R4: low voltage
    vpp_ok = 1'b0;
    start_mode(8);
    chk("R3 ready falls on confirm", status, 8'h00);
    @(negedge clk);
    wait_bit(7, 1'b1);
    chk("R4 low voltage", status, 8'h88);
    rd_expect(8, 8'hFF, "R4 array unchanged");
    vpp_ok = 1'b1;

    // R5 / R12
    lock_mask = 4'b0100;
    start_mode(16);
    @(negedge clk);
    wait_bit(7, 1'b1);
    chk("R5 locked block", status, 8'h82);
    bus_wr(16, 8'h55);
    chk("R12 error persists in idle", status, 8'h82);
    lock_mask = '0;

    // main stream on block 1
    start_mode(8);
    chk("R12 errors cleared on confirm", status, 8'h00);
    repeat (SETUP_CYC + 4) @(negedge clk);
    rd_expect(0, 8'h00, "R3 read returns status");
    bus_wr(8, 8'hA5);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    chk("R6 pulse length", n, PULSE_CYC);
    bus_wr(9, 8'h3C); wait_bit(0, 1'b0);
    bus_wr(9, 8'hF0); wait_bit(0, 1'b0);
    bus_wr(10, 8'h0F);
    bus_wr(11, 8'h00);   // lands while busy
    wait_bit(0, 1'b0);
    chk("R6 ready after pulse", status, 8'h00);
    bus_wr(0, 8'h00);    // outside block 1
    @(negedge clk);
    wait_bit(7, 1'b1);
    chk("R9 exit status", status, 8'h80);
    rd_expect(0, 8'hFF, "R9 outside word unchanged");
    rd_expect(8, 8'hA5, "R7 single write");
    rd_expect(9, 8'h30, "R7 AND of two writes");
    rd_expect(10, 8'h0F, "R7 third word");
    rd_expect(11, 8'hFF, "R8 busy write ignored");

    // R10: missed pulse repaired in verify
    start_mode(24);
    repeat (SETUP_CYC + 4) @(negedge clk);
    cell_weak = 1'b1;
    bus_wr(24, 8'h12);
    wait_bit(0, 1'b0);
    cell_weak = 1'b0;
    bus_wr(0, 8'h00);
    @(negedge clk);
    wait_bit(7, 1'b1);
    chk("R10 verify repair status", status, 8'h80);
    rd_expect(24, 8'h12, "R10 repaired word");

    // R11: retry limit
    start_mode(0);
    repeat (SETUP_CYC + 4) @(negedge clk);
    cell_weak = 1'b1;
    bus_wr(2, 8'h0F);
    wait_bit(0, 1'b0);
    bus_wr(31, 8'h00);
    @(negedge clk);
    wait_bit(7, 1'b1);
    cell_weak = 1'b0;
    chk("R11 program fail", status, 8'h90);
    rd_expect(2, 8'hFF, "R11 word never programmed");
    rd_expect(31, 8'hFF, "R9 outside word unchanged");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule